// File: doc/BRIEF.md
# Nibble-Wide Call/Return Stack Controller

This block runs the subroutine stack of a small 4-bit processor whose data RAM is organised in nibbles. It owns an 8-bit stack pointer and a stack-bank select bit. It turns six kinds of stack command into sequences of single-nibble RAM accesses. The commands are subroutine call, return, register-pair push and pop, and bank-select push and pop. A call saves a 14-bit program counter together with the memory-bank-enable and register-bank-enable flags as six nibbles in a fixed slot pattern below the stack pointer. A return brings them back.

The instruction decoder presents a command with its operands while `busy` is low. The block then performs one RAM access per clock and raises a one-cycle completion pulse with the restored values whenever the command was a read. The RAM read path is combinational: `ram_rdata` must reflect `ram_addr` within the same cycle. The stack area lives in RAM bank 0 or bank 1, chosen by a select bit that may be rewritten only while the block is idle.

Top module: `nibble_stack_ctrl`

## Requirements
- R1: After reset the stack pointer is 0, the stack bank is 0, the restored flag outputs and result outputs are 0, `busy` is low and no RAM write is issued.
- R2: Command code 0 (call) writes six nibbles and then lowers SP by 6. The nibble at SP-1 is 0000. SP-2 holds {00, mbe, rbe}. SP-3 holds pc[7:4]. SP-4 holds pc[3:0]. SP-5 holds {00, pc[13:12]}. SP-6 holds pc[11:8].
- R3: Command code 1 (return) reads SP..SP+5 in the layout of R2 and raises SP by 6. It drives the rebuilt 14-bit PC and both flags on the outputs and pulses `ret_done` for one cycle.
- R4: Command code 2 writes pair[7:4] to SP-1 and pair[3:0] to SP-2 and lowers SP by 2. Code 3 rebuilds the pair as {nibble at SP+1, nibble at SP}, raises SP by 2 and pulses `pair_done`.
- R5: Command code 4 writes the 4-bit memory-bank select to SP-1 and {00, 2-bit register-bank select} to SP-2 and lowers SP by 2. Code 5 restores the memory-bank select from SP+1 and the register-bank select from SP[1:0], raises SP by 2 and pulses `bank_done`.
- R6: Every RAM address is {stack bank, 8-bit slot pointer}. `sbs_wr` loads the stack bank from `sbs_bank` only while `busy` is low; while busy it is ignored.
- R7: Each command takes one clock per nibble. `busy` is high for exactly 6 cycles for call and return, and exactly 2 cycles for the other commands.
- R8: A command presented while `busy` is high is ignored, and so are command codes 6 and 7. Neither starts a sequence or moves SP.
- R9: The stack pointer and every slot address wrap modulo 256 within the selected bank.
- R10: At most one completion pulse is high in any cycle. It lasts one cycle and coincides with `busy` falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command code (0 call, 1 return, 2 push pair, 3 pop pair, 4 push banks, 5 pop banks) |
| pc_in | input | 14 | Program counter to save on call |
| mbe_in | input | 1 | Memory-bank-enable flag to save on call |
| rbe_in | input | 1 | Register-bank-enable flag to save on call |
| pair_in | input | 8 | Register pair to push |
| mbs_in | input | 4 | Memory-bank select to push |
| rbs_in | input | 2 | Register-bank select to push |
| sbs_wr | input | 1 | Stack-bank select write strobe |
| sbs_bank | input | 1 | New stack bank |
| ram_rdata | input | 4 | RAM read nibble (combinational from ram_addr) |
| ram_addr | output | 9 | RAM nibble address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 4 | RAM write nibble |
| busy | output | 1 | Sequence in progress |
| sp_out | output | 8 | Current stack pointer |
| stack_bank | output | 1 | Current stack bank |
| pc_out | output | 14 | PC restored by return |
| mbe_out | output | 1 | Restored memory-bank-enable flag |
| rbe_out | output | 1 | Restored register-bank-enable flag |
| ret_done | output | 1 | Return finished (one cycle) |
| pair_out | output | 8 | Popped register pair |
| pair_done | output | 1 | Pair pop finished (one cycle) |
| mbs_out | output | 4 | Popped memory-bank select |
| rbs_out | output | 2 | Popped register-bank select |
| bank_done | output | 1 | Bank pop finished (one cycle) |

## Verification
The assertions assume that the RAM answers a read in the same cycle and that no other agent writes the stack slots while a sequence runs. They also assume that the decoder pairs every pop or return with a push of the same kind, so that restored values have a meaning. The stimulus keeps to these assumptions. A bench RAM model holds all 512 nibbles with a combinational read. Every pop and return matches the most recent push of its own kind. Commands and bank writes that arrive during a busy window are the only out-of-order traffic, and the requirements say they must be dropped.

// File: rtl/nstk_pkg.sv
package nstk_pkg;

    localparam int NIB_W     = 4;
    localparam int PC_W      = 14;
    localparam int SP_W      = 8;
    localparam int BANK_W    = 1;
    localparam int PAIR_W    = 8;
    localparam int MBS_W     = 4;
    localparam int RBS_W     = 2;
    localparam int MAX_SLOTS = 6;
    localparam int STEP_W    = $clog2(MAX_SLOTS);
    localparam int ADDR_W    = BANK_W + SP_W;
    // slots whose read data the unpacker actually needs
    localparam int KEEP_SLOTS = MAX_SLOTS - 1;

    typedef enum logic [2:0] {
        OP_CALL  = 3'd0,
        OP_RET   = 3'd1,
        OP_PUSHP = 3'd2,
        OP_POPP  = 3'd3,
        OP_PUSHB = 3'd4,
        OP_POPB  = 3'd5
    } op_e;

    typedef logic [NIB_W-1:0] nib_t;

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic              mbe;
        logic              rbe;
        logic [PAIR_W-1:0] pair;
        logic [MBS_W-1:0]  mbs;
        logic [RBS_W-1:0]  rbs;
    } operands_t;

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic              mbe;
        logic              rbe;
        logic [PAIR_W-1:0] pair;
        logic [MBS_W-1:0]  mbs;
        logic [RBS_W-1:0]  rbs;
    } result_t;

    function automatic logic op_legal(input logic [2:0] code);
        return code <= 3'd5;
    endfunction

    function automatic logic [STEP_W-1:0] op_len(input op_e op);
        case (op)
            OP_CALL, OP_RET: return STEP_W'(MAX_SLOTS);
            default:         return STEP_W'(2);
        endcase
    endfunction

    function automatic logic op_writes(input op_e op);
        return (op == OP_CALL) || (op == OP_PUSHP) || (op == OP_PUSHB);
    endfunction

endpackage

// File: rtl/nstk_slot_mux.sv
module nstk_slot_mux
    import nstk_pkg::*;
#(
    parameter int STEPS = MAX_SLOTS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  op_e                   op,
    input  logic [STEP_W-1:0]     step,
    input  operands_t             opnd,
    output nib_t                  wdata
);

    localparam int SW = $clog2(STEPS);

    // step n writes the slot n+1 below the stack pointer
    always_comb begin
        wdata = '0;
        case (op)
            OP_CALL: begin
                case (step)
                    STEP_W'(0): wdata = 4'b0000;
                    STEP_W'(1): wdata = {2'b00, opnd.mbe, opnd.rbe};
                    STEP_W'(2): wdata = opnd.pc[7:4];
                    STEP_W'(3): wdata = opnd.pc[3:0];
                    STEP_W'(4): wdata = {2'b00, opnd.pc[13:12]};
                    STEP_W'(5): wdata = opnd.pc[11:8];
                    default:    wdata = '0;
                endcase
            end
            OP_PUSHP: wdata = (step == '0) ? opnd.pair[7:4] : opnd.pair[3:0];
            OP_PUSHB: wdata = (step == '0) ? opnd.mbs : {2'b00, opnd.rbs};
            default:  wdata = '0;
        endcase
    end

    AST_CALL_PCHI_PAD: assert property (@(posedge clk) disable iff (rst)
        (we && op == OP_CALL && step == STEP_W'(4)) |-> (wdata[3:2] == 2'b00)) else $error("pc slot pad"); // R2
    AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        we |-> (32'(step) < STEPS) && (SW > 0)) else $error("step range"); // R7

endmodule

// File: rtl/nstk_unpack.sv
module nstk_unpack
    import nstk_pkg::*;
(
    input  logic [KEEP_SLOTS-1:0][NIB_W-1:0] slots,
    output result_t                           res
);

    // slot i is the nibble read at SP+i
    logic unused_pad;
    assign unused_pad = ^{slots[1][3:2], slots[4][3:2]};

    always_comb begin
        res.pc   = {slots[1][1:0], slots[0], slots[3], slots[2]};
        res.mbe  = slots[4][1];
        res.rbe  = slots[4][0];
        res.pair = {slots[1], slots[0]};
        res.mbs  = slots[1];
        res.rbs  = slots[0][RBS_W-1:0];
    end

endmodule

// File: rtl/nstk_seq.sv
module nstk_seq
    import nstk_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cmd_valid,
    input  logic [2:0]                        cmd_op,
    input  logic                              sbs_wr,
    input  logic [BANK_W-1:0]                 sbs_bank,
    input  nib_t                              ram_rdata,
    output logic                              busy,
    output logic                              accept,
    output logic                              last,
    output op_e                               op,
    output logic [STEP_W-1:0]                 step,
    output logic [SP_W-1:0]                   sp,
    output logic [BANK_W-1:0]                 bank,
    output logic                              ram_we,
    output logic [ADDR_W-1:0]                 ram_addr,
    output logic [KEEP_SLOTS-1:0][NIB_W-1:0]  slots
);

    logic                              busy_q;
    op_e                               op_q;
    logic [STEP_W-1:0]                 step_q;
    logic [SP_W-1:0]                   sp_q;
    logic [BANK_W-1:0]                 bank_q;
    logic [KEEP_SLOTS-1:0][NIB_W-1:0]  rbuf_q;
    logic                              wr_mode;
    logic [SP_W-1:0]                   slot_ptr;

    assign accept  = cmd_valid && !busy_q && op_legal(cmd_op);
    assign wr_mode = op_writes(op_q);
    assign last    = busy_q && (step_q == STEP_W'(op_len(op_q) - STEP_W'(1)));

    always_comb begin
        if (wr_mode) slot_ptr = sp_q - SP_W'(step_q) - SP_W'(1);
        else         slot_ptr = sp_q + SP_W'(step_q);
    end

    assign ram_addr = {bank_q, slot_ptr};
    assign ram_we   = busy_q && wr_mode;

    // merge the nibble being read this cycle with the ones already captured
    always_comb begin
        slots = rbuf_q;
        for (int i = 0; i < KEEP_SLOTS; i++) begin
            if (busy_q && !wr_mode && step_q == STEP_W'(i)) slots[i] = ram_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            op_q   <= OP_CALL;
            step_q <= '0;
            sp_q   <= '0;
            bank_q <= '0;
            rbuf_q <= '0;
        end else begin
            if (sbs_wr && !busy_q) bank_q <= sbs_bank;
            if (accept) begin
                busy_q <= 1'b1;
                op_q   <= op_e'(cmd_op);
                step_q <= '0;
            end else if (busy_q) begin
                for (int i = 0; i < KEEP_SLOTS; i++) begin
                    if (!wr_mode && step_q == STEP_W'(i)) rbuf_q[i] <= ram_rdata;
                end
                if (last) begin
                    busy_q <= 1'b0;
                    step_q <= '0;
                    if (wr_mode) sp_q <= sp_q - SP_W'(op_len(op_q));
                    else         sp_q <= sp_q + SP_W'(op_len(op_q));
                end else begin
                    step_q <= step_q + STEP_W'(1);
                end
            end
        end
    end

    assign busy = busy_q;
    assign op   = op_q;
    assign step = step_q;
    assign sp   = sp_q;
    assign bank = bank_q;

    AST_WE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> busy_q) else $error("write while idle"); // R8
    AST_SP_MOVES_AT_END: assert property (@(posedge clk) disable iff (rst)
        !$fell(busy_q) |-> $stable(sp_q)) else $error("sp moved mid-sequence"); // R7
    AST_BANK_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |-> $stable(bank_q)) else $error("bank changed while busy"); // R6
    AST_ADDR_IN_BANK: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (ram_addr[ADDR_W-1 -: BANK_W] == bank_q)) else $error("address outside bank"); // R6
    AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !last) |=> busy_q && $stable(op_q)) else $error("sequence disturbed"); // R8

endmodule

// File: rtl/nibble_stack_ctrl.sv
module nibble_stack_ctrl
    import nstk_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         cmd_valid,
    input  logic [2:0]   cmd_op,
    input  logic [13:0]  pc_in,
    input  logic         mbe_in,
    input  logic         rbe_in,
    input  logic [7:0]   pair_in,
    input  logic [3:0]   mbs_in,
    input  logic [1:0]   rbs_in,
    input  logic         sbs_wr,
    input  logic         sbs_bank,
    input  logic [3:0]   ram_rdata,
    output logic [8:0]   ram_addr,
    output logic         ram_we,
    output logic [3:0]   ram_wdata,
    output logic         busy,
    output logic [7:0]   sp_out,
    output logic         stack_bank,
    output logic [13:0]  pc_out,
    output logic         mbe_out,
    output logic         rbe_out,
    output logic         ret_done,
    output logic [7:0]   pair_out,
    output logic         pair_done,
    output logic [3:0]   mbs_out,
    output logic [1:0]   rbs_out,
    output logic         bank_done
);

    logic                              accept;
    logic                              last;
    op_e                               op;
    logic [STEP_W-1:0]                 step;
    logic [KEEP_SLOTS-1:0][NIB_W-1:0]  slots;
    operands_t                         opnd_q;
    result_t                           res;
    result_t                           res_q;
    logic                              ret_done_q, pair_done_q, bank_done_q;

    nstk_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .sbs_wr    (sbs_wr),
        .sbs_bank  (sbs_bank),
        .ram_rdata (ram_rdata),
        .busy      (busy),
        .accept    (accept),
        .last      (last),
        .op        (op),
        .step      (step),
        .sp        (sp_out),
        .bank      (stack_bank),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .slots     (slots)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_q <= '0;
        end else if (accept) begin
            opnd_q.pc   <= pc_in;
            opnd_q.mbe  <= mbe_in;
            opnd_q.rbe  <= rbe_in;
            opnd_q.pair <= pair_in;
            opnd_q.mbs  <= mbs_in;
            opnd_q.rbs  <= rbs_in;
        end
    end

    nstk_slot_mux #(.STEPS(MAX_SLOTS)) u_mux (
        .clk   (clk),
        .rst   (rst),
        .we    (ram_we),
        .op    (op),
        .step  (step),
        .opnd  (opnd_q),
        .wdata (ram_wdata)
    );

    nstk_unpack u_unpack (
        .slots (slots),
        .res   (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q       <= '0;
            ret_done_q  <= 1'b0;
            pair_done_q <= 1'b0;
            bank_done_q <= 1'b0;
        end else begin
            ret_done_q  <= 1'b0;
            pair_done_q <= 1'b0;
            bank_done_q <= 1'b0;
            if (last) begin
                case (op)
                    OP_RET: begin
                        res_q.pc  <= res.pc;
                        res_q.mbe <= res.mbe;
                        res_q.rbe <= res.rbe;
                        ret_done_q <= 1'b1;
                    end
                    OP_POPP: begin
                        res_q.pair  <= res.pair;
                        pair_done_q <= 1'b1;
                    end
                    OP_POPB: begin
                        res_q.mbs   <= res.mbs;
                        res_q.rbs   <= res.rbs;
                        bank_done_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign pc_out    = res_q.pc;
    assign mbe_out   = res_q.mbe;
    assign rbe_out   = res_q.rbe;
    assign pair_out  = res_q.pair;
    assign mbs_out   = res_q.mbs;
    assign rbs_out   = res_q.rbs;
    assign ret_done  = ret_done_q;
    assign pair_done = pair_done_q;
    assign bank_done = bank_done_q;

    AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ret_done, pair_done, bank_done})) else $error("two done pulses"); // R10
    AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (rst)
        (ret_done || pair_done || bank_done) |-> $fell(busy)) else $error("done off busy edge"); // R10
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (ret_done || pair_done || bank_done) |=> !(ret_done || pair_done || bank_done)) else $error("done too long"); // R10
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !ret_done |-> $stable(pc_out)) else $error("pc changed without return"); // R3

endmodule

// File: tb/nibble_stack_ctrl_tb_top.sv
`timescale 1ns/1ps
module nibble_stack_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [13:0] pc_in;
    logic        mbe_in, rbe_in;
    logic [7:0]  pair_in;
    logic [3:0]  mbs_in;
    logic [1:0]  rbs_in;
    logic        sbs_wr, sbs_bank;
    logic [3:0]  ram_rdata;
    logic [8:0]  ram_addr;
    logic        ram_we;
    logic [3:0]  ram_wdata;
    logic        busy;
    logic [7:0]  sp_out;
    logic        stack_bank;
    logic [13:0] pc_out;
    logic        mbe_out, rbe_out, ret_done;
    logic [7:0]  pair_out;
    logic        pair_done;
    logic [3:0]  mbs_out;
    logic [1:0]  rbs_out;
    logic        bank_done;

    always #2.5 clk = ~clk;

    nibble_stack_ctrl dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .pc_in(pc_in), .mbe_in(mbe_in), .rbe_in(rbe_in), .pair_in(pair_in),
        .mbs_in(mbs_in), .rbs_in(rbs_in), .sbs_wr(sbs_wr), .sbs_bank(sbs_bank),
        .ram_rdata(ram_rdata), .ram_addr(ram_addr), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .busy(busy), .sp_out(sp_out),
        .stack_bank(stack_bank), .pc_out(pc_out), .mbe_out(mbe_out),
        .rbe_out(rbe_out), .ret_done(ret_done), .pair_out(pair_out),
        .pair_done(pair_done), .mbs_out(mbs_out), .rbs_out(rbs_out),
        .bank_done(bank_done)
    );

    // nibble RAM model, combinational read
    logic [3:0] mem [0:511];
    assign ram_rdata = mem[ram_addr];
    always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard: kind 0 return {pc,mbe,rbe}, 1 pair, 2 banks {mbs,rbs}
    typedef struct { int kind; logic [31:0] val; } exp_t;
    exp_t exp_q[$];

    // bench-side LIFOs of pushed values, by kind
    logic [31:0] call_stk[$];
    logic [31:0] pair_stk[$];
    logic [31:0] bank_stk[$];

    int model_sp = 0;

    always @(negedge clk) begin
        if (!rst && (ret_done || pair_done || bank_done)) begin
            exp_t e;
            int   k;
            logic [31:0] v;
            k = ret_done ? 0 : (pair_done ? 1 : 2);
            v = ret_done ? 32'({pc_out, mbe_out, rbe_out})
              : (pair_done ? 32'(pair_out) : 32'({mbs_out, rbs_out}));
            if (exp_q.size() == 0) begin
                chk("R10 unexpected done", 32'(k), 32'hFF);
            end else begin
                e = exp_q.pop_front();
                chk(e.kind == 0 ? "R3 return kind" : (e.kind == 1 ? "R4 pop pair kind" : "R5 pop bank kind"), 32'(k), 32'(e.kind));
                chk(e.kind == 0 ? "R3 return value" : (e.kind == 1 ? "R4 pop pair value" : "R5 pop bank value"), v, e.val);
            end
        end
    end

    function automatic int len_of(input logic [2:0] op);
        return (op <= 3'd1) ? 6 : 2;
    endfunction

    // drive one command; hold=1 keeps cmd_valid high with another code and pulses sbs_wr while busy
    task automatic do_cmd(input logic [2:0] op, input logic [13:0] pc, input logic mbe,
                          input logic rbe, input logic [7:0] pair, input logic [3:0] mbs,
                          input logic [1:0] rbs, input bit hold);
        int cyc;
        exp_t e;
        logic [31:0] v;
        case (op)
            3'd0: call_stk.push_back(32'({pc, mbe, rbe}));
            3'd1: begin v = call_stk.pop_back(); e.kind = 0; e.val = v; exp_q.push_back(e); end
            3'd2: pair_stk.push_back(32'(pair));
            3'd3: begin v = pair_stk.pop_back(); e.kind = 1; e.val = v; exp_q.push_back(e); end
            3'd4: bank_stk.push_back(32'({mbs, rbs}));
            default: begin v = bank_stk.pop_back(); e.kind = 2; e.val = v; exp_q.push_back(e); end
        endcase
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; pc_in = pc; mbe_in = mbe; rbe_in = rbe;
        pair_in = pair; mbs_in = mbs; rbs_in = rbs;
        @(negedge clk);
        if (hold) begin
            cmd_op = 3'd2; sbs_wr = 1'b1; sbs_bank = ~stack_bank;
        end else begin
            cmd_valid = 1'b0;
        end
        cyc = 0;
        while (busy && cyc < 20) begin
            cyc++;
            @(negedge clk);
            sbs_wr = 1'b0;
        end
        cmd_valid = 1'b0;
        chk("R7 busy length", 32'(cyc), 32'(len_of(op)));
        model_sp = (op == 3'd0 || op == 3'd2 || op == 3'd4) ? (model_sp - len_of(op)) & 255
                                                             : (model_sp + len_of(op)) & 255;
        chk(hold ? "R8 sp after busy-time traffic" : "R9 sp after command", 32'(sp_out), 32'(model_sp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 4'h0;
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; pc_in = '0; mbe_in = 0; rbe_in = 0;
        pair_in = '0; mbs_in = '0; rbs_in = '0; sbs_wr = 0; sbs_bank = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 sp", 32'(sp_out), 0);
        chk("R1 bank", 32'(stack_bank), 0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 flags", 32'({mbe_out, rbe_out}), 0);
        chk("R1 results", 32'({pc_out, pair_out, mbs_out, rbs_out}), 0);
        chk("R1 no write", 32'(ram_we), 0);

        // R2 call from SP=0, wraps to 0xFA (R9)
        do_cmd(3'd0, 14'h2ABC, 1'b1, 1'b0, 8'h00, 4'h0, 2'h0, 0);
        chk("R2 slot SP-6", 32'(mem[9'h0FA]), 32'hA);
        chk("R2 slot SP-5", 32'(mem[9'h0FB]), 32'h2);
        chk("R2 slot SP-4", 32'(mem[9'h0FC]), 32'hC);
        chk("R2 slot SP-3", 32'(mem[9'h0FD]), 32'hB);
        chk("R2 slot SP-2", 32'(mem[9'h0FE]), 32'h2);
        chk("R2 slot SP-1", 32'(mem[9'h0FF]), 32'h0);

        // R4 push pair
        do_cmd(3'd2, 14'h0, 0, 0, 8'h5E, 4'h0, 2'h0, 0);
        chk("R4 pair hi at SP-1", 32'(mem[9'h0F9]), 32'h5);
        chk("R4 pair lo at SP-2", 32'(mem[9'h0F8]), 32'hE);

        // R5 push banks
        do_cmd(3'd4, 14'h0, 0, 0, 8'h00, 4'hD, 2'h3, 0);
        chk("R5 mbs at SP-1", 32'(mem[9'h0F7]), 32'hD);
        chk("R5 rbs at SP-2", 32'(mem[9'h0F6]), 32'h3);

        // R5 pop banks with R8/R6 traffic during busy
        do_cmd(3'd5, 14'h0, 0, 0, 8'h00, 4'h0, 2'h0, 1);
        chk("R6 bank write while busy ignored", 32'(stack_bank), 0);
        chk("R8 not restarted", 32'(busy), 0);

        // R4 pop pair
        do_cmd(3'd3, 14'h0, 0, 0, 8'h00, 4'h0, 2'h0, 0);

        // R8 illegal codes
        for (int c = 6; c < 8; c++) begin
            @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 3'(c);
            @(negedge clk);
            chk("R8 illegal code stays idle", 32'(busy), 0);
            chk("R8 illegal code keeps sp", 32'(sp_out), 32'(model_sp));
            cmd_valid = 1'b0;
        end

        // R3 return, SP back to 0 (R9 wrap)
        do_cmd(3'd1, 14'h0, 0, 0, 8'h00, 4'h0, 2'h0, 0);
        chk("R3 mbe restored", 32'(mbe_out), 1);
        chk("R3 rbe restored", 32'(rbe_out), 0);

        // R6 switch to bank 1
        @(negedge clk); sbs_wr = 1'b1; sbs_bank = 1'b1;
        @(negedge clk); sbs_wr = 1'b0;
        chk("R6 bank select", 32'(stack_bank), 1);
        do_cmd(3'd0, 14'h1234, 1'b0, 1'b1, 8'h00, 4'h0, 2'h0, 0);
        chk("R6 bank1 slot SP-6", 32'(mem[9'h1FA]), 32'h2);
        chk("R6 bank1 slot SP-2", 32'(mem[9'h1FE]), 32'h1);
        chk("R6 bank0 untouched", 32'(mem[9'h0FA]), 32'hA);
        do_cmd(3'd1, 14'h0, 0, 0, 8'h00, 4'h0, 2'h0, 0);
        @(negedge clk); sbs_wr = 1'b1; sbs_bank = 1'b0;
        @(negedge clk); sbs_wr = 1'b0;

        // nested mix, LIFO by kind
        do_cmd(3'd0, 14'h3FFF, 1, 1, 8'h00, 4'h0, 2'h0, 0);
        do_cmd(3'd2, 14'h0, 0, 0, 8'hA7, 4'h0, 2'h0, 0);
        do_cmd(3'd2, 14'h0, 0, 0, 8'h19, 4'h0, 2'h0, 0);
        do_cmd(3'd0, 14'h0001, 0, 0, 8'h00, 4'h0, 2'h0, 0);
        do_cmd(3'd4, 14'h0, 0, 0, 8'h00, 4'h6, 2'h1, 0);
        do_cmd(3'd5, 14'h0, 0, 0, 8'h00, 4'h0, 2'h0, 0);
        do_cmd(3'd1, 14'h0, 0, 0, 8'h00, 4'h0, 2'h0, 0);
        do_cmd(3'd3, 14'h0, 0, 0, 8'h00, 4'h0, 2'h0, 0);
        do_cmd(3'd3, 14'h0, 0, 0, 8'h00, 4'h0, 2'h0, 0);
        do_cmd(3'd1, 14'h0, 0, 0, 8'h00, 4'h0, 2'h0, 0);

        repeat (3) @(negedge clk);
        chk("R10 all done pulses seen", 32'(exp_q.size()), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule